// File: doc/BRIEF.md
# Configuration Output Selector with Held Bit

The block sets up board-level configuration without jumpers. It drives five configuration pins. Each pin takes one of two sources, picked by a single select line: a bit of a stored 6-bit configuration word, or one of five external inputs. A sixth pin carries the top bit of the stored word through a hold stage that the same select line controls. While select is low the sixth pin follows the stored bit. While select is high it keeps the value it had just before select rose.

An active-low force line clears all six pins, but only while select is low. While select is high the force line has no effect. Every pin leaves the block as an open-drain pull-low enable, so the board-level pullup sets the logic level. The hold stage is a register clocked by the block clock. It captures on each rising clock edge at which select is low, so "the moment select rose" means the last such edge.

Top module: `cfgsel_top`

## Requirements
- R1: With sel_i = 0 and force_ni = 1, configuration channel i (i = 0..4, channel 0 is A and channel 4 is E) carries cfg_word_i[i]. The change shows at the ports in the same cycle.
- R2: With sel_i = 1, configuration channel i carries ext_i[i].
- R3: With sel_i = 0 and force_ni = 1, the held pin carries cfg_word_i[5] with no clock delay.
- R4: With sel_i = 1, the held pin keeps the value it showed at the last rising clock edge at which sel_i was 0. Later changes of cfg_word_i[5] do not reach it.
- R5: With sel_i = 0 and force_ni = 0, all five channels and the held pin carry logic 0.
- R6: With sel_i = 1, force_ni has no effect: the channels still pass ext_i and the held pin keeps its value.
- R7: If force_ni was 0 at the last capture edge before sel_i rose, the held pin carries 0 while sel_i stays 1, whatever cfg_word_i[5] is.
- R8: Every output is a pull-low enable. An enable of 1 means the pin reads logic 0 and an enable of 0 means the pin reads 1 through its pullup.
- R9: While rst_ni = 0 the held value is cleared to 0. With sel_i = 1 during reset, hold_pull_o is therefore 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock of the hold register |
| rst_ni | input | 1 | Active-low reset, clears the held value |
| cfg_word_i | input | 6 | Stored configuration word; bits 0..4 feed the channels, bit 5 feeds the held pin |
| ext_i | input | 5 | External channel sources used while select is high |
| sel_i | input | 1 | Source select and hold control |
| force_ni | input | 1 | Active-low clear, effective only while select is low |
| mux_pull_o | output | 5 | Pull-low enables of the five configuration channels |
| hold_pull_o | output | 1 | Pull-low enable of the held pin |

## Verification
The only state in the block is the held bit. If that bit is wrong, nothing shows while select is low, because the pin then follows the stored word directly. The error appears on hold_pull_o in the first cycle after select rises and stays there until select falls. The bench therefore raises select after setting up known values of the stored bit and the force line, and then changes the stored bit while select stays high. A wrong source choice or a wrong force gate on the channels appears in the same cycle, so each pattern is compared before the next clock edge.

// File: rtl/cfgsel_pkg.sv
package cfgsel_pkg;
   localparam int unsigned CHAN_DEFAULT = 5;

   typedef enum logic {
      SRC_STORED   = 1'b0,
      SRC_EXTERNAL = 1'b1
   } src_e;

   function automatic logic to_pull(input logic level);
      return ~level;
   endfunction
endpackage

// File: rtl/cfgsel_mux.sv
module cfgsel_mux #(
   parameter int unsigned N_CHAN = cfgsel_pkg::CHAN_DEFAULT
) (
   input  logic [N_CHAN-1:0] stored_i,
   input  logic [N_CHAN-1:0] ext_i,
   input  logic              sel_i,
   input  logic              force_ni,
   output logic [N_CHAN-1:0] level_o
);
   import cfgsel_pkg::*;

   src_e src;
   assign src = src_e'(sel_i);

   for (genvar i = 0; i < N_CHAN; i++) begin : g_chan
      always_comb begin
         if (src == SRC_EXTERNAL) begin
            level_o[i] = ext_i[i];
         end else begin
            level_o[i] = stored_i[i] & force_ni;
         end
      end
   end
endmodule

// File: rtl/cfgsel_hold.sv
module cfgsel_hold (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic bit_i,
   input  logic sel_i,
   input  logic force_ni,
   output logic level_o
);
   logic live;
   logic held_q;

   assign live = bit_i & force_ni;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         held_q <= 1'b0;
      end else if (!sel_i) begin
         held_q <= live;
      end
   end

   assign level_o = sel_i ? held_q : live;
endmodule

// File: rtl/cfgsel_od.sv
module cfgsel_od #(
   parameter int unsigned WIDTH = 1
) (
   input  logic [WIDTH-1:0] level_i,
   output logic [WIDTH-1:0] pull_o
);
   for (genvar i = 0; i < WIDTH; i++) begin : g_pin
      assign pull_o[i] = cfgsel_pkg::to_pull(level_i[i]);
   end
endmodule

// File: rtl/cfgsel_top.sv
module cfgsel_top #(
   parameter int unsigned N_CHAN = cfgsel_pkg::CHAN_DEFAULT,
   localparam int unsigned WORD_W = N_CHAN + 1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic [WORD_W-1:0] cfg_word_i,
   input  logic [N_CHAN-1:0] ext_i,
   input  logic              sel_i,
   input  logic              force_ni,
   output logic [N_CHAN-1:0] mux_pull_o,
   output logic              hold_pull_o
);
   if (N_CHAN < 1 || N_CHAN > 32) begin : g_bad_width
      $error("cfgsel_top: N_CHAN must lie in 1..32");
   end

   logic [N_CHAN-1:0] chan_level;
   logic              hold_level;

   cfgsel_mux #(.N_CHAN(N_CHAN)) i_mux (
      .stored_i (cfg_word_i[N_CHAN-1:0]),
      .ext_i    (ext_i),
      .sel_i    (sel_i),
      .force_ni (force_ni),
      .level_o  (chan_level)
   );

   cfgsel_hold i_hold (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .bit_i    (cfg_word_i[WORD_W-1]),
      .sel_i    (sel_i),
      .force_ni (force_ni),
      .level_o  (hold_level)
   );

   cfgsel_od #(.WIDTH(WORD_W)) i_od (
      .level_i ({hold_level, chan_level}),
      .pull_o  ({hold_pull_o, mux_pull_o})
   );
endmodule

// File: rtl/cfgsel_checker.sv
module cfgsel_checker #(
   parameter int unsigned N_CHAN = 5
) (
   input logic              clk_i,
   input logic              rst_ni,
   input logic [N_CHAN:0]   cfg_word_i,
   input logic [N_CHAN-1:0] ext_i,
   input logic              sel_i,
   input logic              force_ni,
   input logic [N_CHAN-1:0] mux_pull_o,
   input logic              hold_pull_o
);
   AST_STORED_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!sel_i && force_ni) |-> (mux_pull_o == ~cfg_word_i[N_CHAN-1:0])); // R1

   AST_EXT_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      sel_i |-> (mux_pull_o == ~ext_i)); // R2

   AST_HOLD_FOLLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!sel_i && force_ni) |-> (hold_pull_o == ~cfg_word_i[N_CHAN])); // R3

   AST_HOLD_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sel_i && $past(sel_i)) |-> $stable(hold_pull_o)); // R4

   AST_FORCE_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!sel_i && !force_ni) |-> (mux_pull_o == '1 && hold_pull_o)); // R5

   AST_CAPTURE_FORCED: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sel_i && $past(rst_ni) && !$past(sel_i) && !$past(force_ni)) |-> hold_pull_o); // R7
endmodule

bind cfgsel_top cfgsel_checker #(.N_CHAN(N_CHAN)) i_cfgsel_checker (
   .clk_i       (clk_i),
   .rst_ni      (rst_ni),
   .cfg_word_i  (cfg_word_i),
   .ext_i       (ext_i),
   .sel_i       (sel_i),
   .force_ni    (force_ni),
   .mux_pull_o  (mux_pull_o),
   .hold_pull_o (hold_pull_o)
);

// File: tb/test_cfgsel_top.sv
module test_cfgsel_top;
   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [5:0] word = '0;
   logic [4:0] ext = '0;
   logic       sel = 1'b1;
   logic       frc_n = 1'b1;
   logic [4:0] mux_pull;
   logic       hold_pull;

   int n_cmp = 0;
   int n_bad = 0;
   logic m_held = 1'b0;

   typedef struct {
      logic [4:0] mux_lvl;
      logic       hold_lvl;
      string      tag;
   } exp_t;

   exp_t sb_q[$];
   event ev_sample;
   bit   done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   cfgsel_top i_cfgsel_top (
      .clk_i       (clk),
      .rst_ni      (rst_n),
      .cfg_word_i  (word),
      .ext_i       (ext),
      .sel_i       (sel),
      .force_ni    (frc_n),
      .mux_pull_o  (mux_pull),
      .hold_pull_o (hold_pull)
   );

   task automatic check(input string tag, input logic [4:0] act, input logic [4:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%b expected=%b", tag, act, exp);
      end
   endtask

   // Monitor: resolves pull enables against a pullup (R8) and compares.
   initial begin
      forever begin
         @(ev_sample);
         while (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            check({e.tag, " channels (R8)"}, ~mux_pull, e.mux_lvl);
            check({e.tag, " held (R8)"}, {4'b0, ~hold_pull}, {4'b0, e.hold_lvl});
         end
      end
   end

   // Driver: one pattern per cycle, expected value from the requirements.
   task automatic apply(input logic [5:0] w, input logic [4:0] x, input logic s,
                        input logic f, input string tag);
      exp_t e;
      @(negedge clk);
      word = w; ext = x; sel = s; frc_n = f;
      #1;
      if (s) begin
         e.mux_lvl  = x;
         e.hold_lvl = m_held;
      end else begin
         e.mux_lvl  = f ? w[4:0] : 5'b0;
         e.hold_lvl = f & w[5];
      end
      e.tag = tag;
      sb_q.push_back(e);
      ->ev_sample;
      @(posedge clk);
      if (!s) m_held = f & w[5];
   endtask

   initial begin
      #(CLK_PERIOD * 5000);
      if (!done) begin
         n_cmp++; n_bad++;
         $display("FAIL watchdog expired");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      word = 6'h3F; ext = 5'h15;
      repeat (3) @(posedge clk);
      @(negedge clk);
      check("R9 reset held", {4'b0, hold_pull}, 5'b1);
      check("R2 during reset", ~mux_pull, 5'h15);
      rst_n = 1'b1;

      apply(6'h3F, 5'h15, 1'b1, 1'b1, "R9 after reset");
      apply(6'h15, 5'h0A, 1'b0, 1'b1, "R1 pattern 15");
      apply(6'h2A, 5'h15, 1'b0, 1'b1, "R1 R3 pattern 2A");
      apply(6'h3F, 5'h00, 1'b0, 1'b1, "R1 R3 all ones");
      apply(6'h00, 5'h1F, 1'b0, 1'b1, "R1 R3 all zeros");
      apply(6'h13, 5'h13, 1'b1, 1'b1, "R2 R4 ext 13");
      apply(6'h0C, 5'h0C, 1'b1, 1'b1, "R2 ext 0C");
      // held 1, then stored bit 5 drops
      apply(6'h20, 5'h00, 1'b0, 1'b1, "R3 bit5 set");
      apply(6'h00, 5'h07, 1'b1, 1'b1, "R4 hold one");
      apply(6'h1F, 5'h18, 1'b1, 1'b1, "R4 hold after change");
      // held 0, then stored bit 5 rises
      apply(6'h1F, 5'h00, 1'b0, 1'b1, "R3 bit5 clear");
      apply(6'h3F, 5'h01, 1'b1, 1'b1, "R4 hold zero");
      // force in select-low state
      apply(6'h3F, 5'h1F, 1'b0, 1'b0, "R5 forced clear");
      apply(6'h3F, 5'h00, 1'b1, 1'b1, "R7 forced capture");
      apply(6'h3F, 5'h0F, 1'b1, 1'b0, "R7 R6 still zero");
      // force in select-high state
      apply(6'h20, 5'h00, 1'b0, 1'b1, "R3 rearm");
      apply(6'h00, 5'h1F, 1'b1, 1'b0, "R6 force ignored");
      apply(6'h00, 5'h0A, 1'b1, 1'b1, "R6 force released");
      apply(6'h00, 5'h0A, 1'b0, 1'b1, "R1 select back low");

      @(negedge clk);
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule